// File: doc/BRIEF.md
# I2C Target Engine with Clock Stretching

This block is the bus-facing half of an I2C target (slave) device. A fast system clock oversamples the two bus lines. The block finds START, repeated START and STOP conditions, and shifts in the address byte. When the upper seven bits of that byte equal a configurable address, it answers with an acknowledge. The last bit of the address byte then decides the direction. In write direction each received byte goes out to local logic. In read direction the block fetches bytes from local logic and shifts them onto SDA.

Both bus outputs are open-drain enables. A high level pulls the line low and a low level releases it. The local side connects through two byte handshakes. Write bytes leave on `wr_data` and are qualified by `wr_valid`, then accepted with `wr_ready`. Read bytes are requested with `rd_req` and supplied with `rd_data`, qualified by `rd_valid`. If the local side is slow, the block holds SCL low until it can go on, which stalls the master without losing data. The system clock must run at least eight times faster than SCL.

Top module: `i2c_target`

## Requirements
- R1: After reset, and after any STOP condition (SDA rising while SCL is high), `sda_oe`, `scl_oe`, `wr_valid` and `rd_req` are all low.
- R2: A START condition (SDA falling while SCL is high) begins reception of an address byte. That byte is shifted in MSB first, one bit on each SCL rising edge. Bits [7:1] carry the target address and bit 0 the direction (0 = write, 1 = read).
- R3: When the received address equals `own_addr`, the block pulls SDA low for the whole ninth (acknowledge) clock.
- R4: When the address differs from `own_addr`, SDA is released on the ninth clock. After that all four outputs stay low until the next START or STOP.
- R5: In write direction every received data byte is acknowledged. Each byte is presented on `wr_data` with `wr_valid`, and both hold steady until the cycle in which `wr_ready` is sampled high.
- R6: While a write byte waits for `wr_ready`, the block holds SCL low (`scl_oe` high). It releases SCL the cycle after the handshake.
- R7: In read direction `rd_req` rises during an acknowledge clock, either the block's address acknowledge or a master acknowledge. It stays high until `rd_valid` is seen or a START or STOP occurs, so exactly one byte is fetched per acknowledged read slot.
- R8: A read byte is shifted out MSB first. SDA is released for a 1 and pulled low for a 0, and each bit holds over the whole SCL high phase.
- R9: If no read byte has been taken by the falling edge that ends the acknowledge clock, the block holds SCL low until `rd_valid` arrives.
- R10: When the master answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and makes no further request. Bytes clocked after that read as all ones until START or STOP.
- R11: A repeated START in the middle of a transaction restarts address reception at once. The new address and direction then take effect as in R3 and R4.
- R12: `sda_oe` changes only while SCL is low on the bus, and `wr_valid` and `rd_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 = pull SCL low (stretch), 0 = release |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| wr_data | output | 8 | Received write byte |
| wr_valid | output | 1 | `wr_data` holds a byte for local logic |
| wr_ready | input | 1 | Local logic accepts the write byte |
| rd_data | input | 8 | Byte to transmit in read direction |
| rd_valid | input | 1 | `rd_data` is valid |
| rd_req | output | 1 | Block asks for the next read byte |

## Verification
A level change on `scl_i` or `sda_i` reaches the engine's registered outputs on the third system clock edge: two synchronizer flops, then the state register. Bus-side results therefore appear within three cycles of an SCL edge. The bench master keeps every SCL phase at 20 cycles and samples SDA only at the end of a high phase, so each acknowledge and read bit has settled long before it is read. Local handshakes finish one edge after both sides are high. The bench drives and samples on the falling clock edge and records a byte only at the handshake edge. Its per-cycle reference checks for idle outputs, data stability and SDA movement all compare values that were last updated on the preceding rising edge.

// File: rtl/twt_pkg.sv
// Shared constants and the engine state type for the I2C target.
package twt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        TS_IDLE,    // bus free or not addressed yet
        TS_ADDR,    // shifting in the address byte
        TS_WRX,     // shifting in a write data byte
        TS_WHOLD,   // byte offered to local logic, SCL held
        TS_WACK,    // driving ACK for address or write byte
        TS_ACKR,    // acknowledge clock ahead of a read byte
        TS_RFETCH,  // SCL held until local logic supplies a byte
        TS_RSETUP,  // one cycle of SDA setup before SCL release
        TS_RTX,     // shifting out a read byte
        TS_IGNORE   // not addressed or read ended by NACK
    } twt_state_e;
endpackage

// File: rtl/twt_sync.sv
// Multi-stage synchronizer for asynchronous bus lines.
// Each line passes through STAGES flops; one more flop gives the previous
// synchronized sample for edge detection. Reset value is 1 (idle bus level).
// Assumes the inputs are plain levels with no handshake.
module twt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_d
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES:0] chain;

            // shift the line through the synchronizer and delay stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-1:0], din[g]};
            end

            assign lvl[g]   = chain[STAGES-1];
            assign lvl_d[g] = chain[STAGES];
        end
    endgenerate
endmodule

// File: rtl/twt_cond.sv
// Bus event decoder working on synchronized samples.
// Produces single-cycle SCL edge strobes and START / STOP strobes.
// Assumes the current and previous samples come from the same pipeline.
module twt_cond (
    input  logic scl,
    input  logic sda,
    input  logic scl_d,
    input  logic sda_d,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_hi_both;

    // classify the transition between the last two samples
    always_comb begin
        scl_hi_both = scl && scl_d;
        scl_rise    = scl && !scl_d;
        scl_fall    = !scl && scl_d;
        start_evt   = scl_hi_both && sda_d && !sda;
        stop_evt    = scl_hi_both && !sda_d && sda;
    end
endmodule

// File: rtl/twt_engine.sv
// Protocol engine of the I2C target.
// Receives the address byte, acknowledges a match, then either receives
// write bytes or transmits read bytes through local byte handshakes, and
// stretches SCL whenever the local side is not ready.
// Assumes edge and condition strobes last one cycle and that the system
// clock is at least 8x the SCL rate, so each SCL low phase spans several
// cycles. Outputs are open-drain enables (1 = pull low).
module twt_engine
    import twt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_req
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    twt_state_e        state;
    logic [CNT_W-1:0]  bcnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              tx_have;
    logic              go_on;

    logic              rd_take;
    logic              tx_ok;
    logic [BYTE_W-1:0] tx_next;
    logic              addr_hit;

    // next read byte: a prefetched one first, otherwise the one on offer now
    always_comb begin
        rd_take  = rd_req && rd_valid;
        tx_ok    = tx_have || rd_take;
        tx_next  = tx_have ? tx_sh : rd_data;
        addr_hit = (rx_sh[BYTE_W-1:1] == own_addr);
    end

    // main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= TS_IDLE;
            bcnt     <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            tx_have  <= 1'b0;
            go_on    <= 1'b0;
            sda_oe   <= 1'b0;
            scl_oe   <= 1'b0;
            wr_data  <= '0;
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
        end else if (start_evt || stop_evt) begin
            state    <= start_evt ? TS_ADDR : TS_IDLE;
            bcnt     <= '0;
            tx_have  <= 1'b0;
            sda_oe   <= 1'b0;
            scl_oe   <= 1'b0;
            wr_valid <= 1'b0;
            rd_req   <= 1'b0;
        end else begin
            case (state)
                TS_IDLE, TS_IGNORE: begin
                    sda_oe <= 1'b0;
                end

                TS_ADDR: begin
                    if (scl_rise && bcnt != CNT_FULL) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bcnt  <= bcnt + 1'b1;
                    end
                    if (scl_fall && bcnt == CNT_FULL) begin
                        if (!addr_hit) begin
                            state <= TS_IGNORE;
                        end else begin
                            sda_oe <= 1'b1;
                            state  <= rx_sh[0] ? TS_ACKR : TS_WACK;
                        end
                    end
                end

                TS_WRX: begin
                    if (scl_rise && bcnt != CNT_FULL) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
                        bcnt  <= bcnt + 1'b1;
                    end
                    if (scl_fall && bcnt == CNT_FULL) begin
                        wr_data  <= rx_sh;
                        wr_valid <= 1'b1;
                        scl_oe   <= 1'b1;
                        sda_oe   <= 1'b1;
                        state    <= TS_WHOLD;
                    end
                end

                TS_WHOLD: begin
                    if (wr_ready) begin
                        wr_valid <= 1'b0;
                        scl_oe   <= 1'b0;
                        state    <= TS_WACK;
                    end
                end

                TS_WACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bcnt   <= '0;
                        state  <= TS_WRX;
                    end
                end

                TS_ACKR: begin
                    if (scl_rise) begin
                        go_on  <= !sda_lvl;
                        rd_req <= !sda_lvl;
                    end else if (scl_fall) begin
                        if (!go_on) begin
                            sda_oe <= 1'b0;
                            state  <= TS_IGNORE;
                        end else if (tx_ok) begin
                            tx_sh   <= tx_next;
                            sda_oe  <= !tx_next[BYTE_W-1];
                            tx_have <= 1'b0;
                            rd_req  <= 1'b0;
                            bcnt    <= '0;
                            state   <= TS_RTX;
                        end else begin
                            sda_oe <= 1'b0;
                            scl_oe <= 1'b1;
                            state  <= TS_RFETCH;
                        end
                    end else if (rd_take) begin
                        tx_sh   <= rd_data;
                        tx_have <= 1'b1;
                        rd_req  <= 1'b0;
                    end
                end

                TS_RFETCH: begin
                    if (rd_valid) begin
                        tx_sh  <= rd_data;
                        sda_oe <= !rd_data[BYTE_W-1];
                        rd_req <= 1'b0;
                        state  <= TS_RSETUP;
                    end
                end

                TS_RSETUP: begin
                    scl_oe <= 1'b0;
                    bcnt   <= '0;
                    state  <= TS_RTX;
                end

                TS_RTX: begin
                    if (scl_fall) begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == CNT_LAST) begin
                            sda_oe <= 1'b0;
                            state  <= TS_ACKR;
                        end else begin
                            sda_oe <= !tx_sh[BYTE_W-2];
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end

                default: state <= TS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_target.sv
// Top level of the I2C target: synchronizer, event decoder and engine.
// Bus lines enter as sampled levels; both bus outputs are pull-low enables
// that the pad logic turns into open-drain drivers.
// Assumes clk is at least 8x the SCL rate; bus events act 3 cycles late.
module i2c_target
    import twt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_req
);
    logic [1:0] bus_lvl;
    logic [1:0] bus_lvl_d;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_seen;
    logic       stop_seen;

    twt_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .lvl   (bus_lvl),
        .lvl_d (bus_lvl_d)
    );

    twt_cond u_cond (
        .scl       (bus_lvl[1]),
        .sda       (bus_lvl[0]),
        .scl_d     (bus_lvl_d[1]),
        .sda_d     (bus_lvl_d[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_seen),
        .stop_evt  (stop_seen)
    );

    twt_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (own_addr),
        .sda_lvl   (bus_lvl[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_seen),
        .stop_evt  (stop_seen),
        .sda_oe    (sda_oe),
        .scl_oe    (scl_oe),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_req    (rd_req)
    );
endmodule

// File: rtl/twt_chk.sv
// Protocol checker for i2c_target, attached by bind below.
// Relates port behaviour to the decoded START / STOP strobes.
module twt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] wr_data,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_req,
    input logic       start_seen,
    input logic       stop_seen
);
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> (!sda_oe && !scl_oe && !rd_req && !wr_valid));

    assert_restart_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (!sda_oe && !scl_oe && !rd_req && !wr_valid));

    assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready && !start_seen && !stop_seen)
            |=> (wr_valid && $stable(wr_data)));

    assert_wr_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> scl_oe);

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !start_seen && !stop_seen) |=> rd_req);

    assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    assert_one_side_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));
endmodule

bind i2c_target twt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .wr_data    (wr_data),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
);

// File: tb/tb_i2c_target.sv
// Bench: behavioural bus master, behavioural local side with queues, and
// a per-cycle reference check of the target's outputs.
module tb_i2c_target;
    localparam int H = 20;   // SCL half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] own_addr = 7'h5A;
    logic       m_scl = 1'b0;  // 1 = master pulls SCL low
    logic       m_sda = 1'b0;  // 1 = master pulls SDA low
    logic       scl_oe, sda_oe, wr_valid, rd_req;
    logic [7:0] wr_data;
    logic       wr_ready = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       rd_valid = 1'b0;
    wire        scl_bus = !(m_scl || scl_oe);
    wire        sda_bus = !(m_sda || sda_oe);

    int  checks = 0, fails = 0;
    int  stretch = 0;
    int  wr_delay = 0, rd_lat = 2;
    int  req_rises = 0;
    bit  mon_on = 1'b0;
    bit  quiet = 1'b0;
    string qtag = "R1";
    logic [7:0] exp_wr[$];
    logic [7:0] rd_q[$];

    always #2 clk = ~clk;

    i2c_target dut (
        .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_req(rd_req)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // ---------------- local side: write acceptor ----------------
    int  wr_wait = 0;
    bit  wr_pend = 1'b0;
    logic [7:0] wr_prev = 8'h00;
    bit  wr_prev_v = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_valid && wr_prev_v)
                chk(wr_data == wr_prev, "R5", "wr_data stable", wr_data, wr_prev);
            if (wr_valid)
                chk(scl_oe == 1'b1, "R6", "SCL held while byte waits", scl_oe, 1);
            chk(!(wr_valid && rd_req), "R12", "one handshake side", {wr_valid, rd_req}, 0);
            wr_prev   = wr_data;
            wr_prev_v = wr_valid && !wr_pend;
            if (wr_pend) begin
                wr_ready = 1'b0;
                wr_pend  = 1'b0;
                wr_wait  = 0;
            end else if (wr_valid) begin
                if (wr_wait >= wr_delay) begin
                    wr_ready = 1'b1;
                    wr_pend  = 1'b1;
                    if (exp_wr.size() == 0)
                        chk(1'b0, "R5", "unexpected write byte", wr_data, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_wr.pop_front();
                        chk(wr_data == e, "R5", "write byte value", wr_data, e);
                    end
                end else wr_wait++;
            end else wr_wait = 0;
        end
    end

    // ---------------- local side: read supplier ----------------
    int  rd_wait = 0;
    bit  rd_pend = 1'b0;
    bit  req_prev = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_req && !req_prev) req_rises++;
            req_prev = rd_req;
            if (rd_pend) begin
                rd_valid = 1'b0;
                rd_pend  = 1'b0;
                rd_wait  = 0;
            end else if (rd_req) begin
                if (rd_wait >= rd_lat) begin
                    rd_data  = (rd_q.size() != 0) ? rd_q.pop_front() : 8'hEE;
                    rd_valid = 1'b1;
                    rd_pend  = 1'b1;
                end else rd_wait++;
            end else rd_wait = 0;
        end
    end

    // ---------------- per-cycle reference checks ----------------
    logic sda_prev = 1'b0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (quiet)
                chk({sda_oe, scl_oe, wr_valid, rd_req} == 4'b0, qtag, "outputs idle",
                    {sda_oe, scl_oe, wr_valid, rd_req}, 0);
            if (sda_oe != sda_prev)
                chk(scl_bus == 1'b0, "R12", "SDA moved while SCL high", scl_bus, 0);
            sda_prev = sda_oe;
        end
    end

    // ---------------- bus master ----------------
    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rel_scl();
        m_scl = 1'b0;
        @(negedge clk);
        while (!scl_bus) begin
            stretch++;
            @(negedge clk);
        end
    endtask

    task automatic m_bit(input bit b, output bit s);
        m_sda = !b;
        wait_cyc(H);
        rel_scl();
        wait_cyc(H);
        s = sda_bus;
        m_scl = 1'b1;
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_cyc(H);
        m_scl = 1'b1; wait_cyc(H);
    endtask

    task automatic m_rstart();
        m_sda = 1'b0; wait_cyc(H);
        rel_scl();    wait_cyc(H);
        m_sda = 1'b1; wait_cyc(H);
        m_scl = 1'b1; wait_cyc(H);
    endtask

    task automatic m_stop();
        m_sda = 1'b1; wait_cyc(H);
        rel_scl();    wait_cyc(H);
        m_sda = 1'b0; wait_cyc(H);
    endtask

    task automatic m_wbyte(input logic [7:0] d, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) m_bit(d[i], s);
        m_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic m_rbyte(output logic [7:0] d, input bit ack);
        bit s;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            m_bit(1'b1, s);
            d = {d[6:0], s};
        end
        m_bit(!ack, s);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        bit ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wait_cyc(3);
        chk({sda_oe, scl_oe, wr_valid, rd_req} == 4'b0, "R1", "reset outputs",
            {sda_oe, scl_oe, wr_valid, rd_req}, 0);
        mon_on = 1'b1; quiet = 1'b1; qtag = "R1";
        wait_cyc(20);

        // write, local side ready at once: no visible stretch
        quiet = 1'b0;
        exp_wr.push_back(8'hA5); exp_wr.push_back(8'h00); exp_wr.push_back(8'hFF);
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        chk(ack, "R2 R3", "write address ACK", ack, 1);
        stretch = 0;
        m_wbyte(8'hA5, ack); chk(ack, "R5", "write byte 1 ACK", ack, 1);
        m_wbyte(8'h00, ack); chk(ack, "R5", "write byte 2 ACK", ack, 1);
        m_wbyte(8'hFF, ack); chk(ack, "R5", "write byte 3 ACK", ack, 1);
        chk(stretch == 0, "R6", "no stretch with ready local side", stretch, 0);
        m_stop();
        quiet = 1'b1; qtag = "R1";
        chk(exp_wr.size() == 0, "R5", "all write bytes delivered", exp_wr.size(), 0);
        wait_cyc(20);

        // write with slow local side: SCL stretched
        quiet = 1'b0; wr_delay = 60;
        exp_wr.push_back(8'h3C);
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        stretch = 0;
        m_wbyte(8'h3C, ack);
        chk(ack, "R5", "slow write ACK", ack, 1);
        chk(stretch >= 30, "R6", "stretch length on slow accept", stretch, 30);
        m_stop();
        quiet = 1'b1; qtag = "R1";
        wr_delay = 0;
        chk(exp_wr.size() == 0, "R5", "slow write byte delivered", exp_wr.size(), 0);
        wait_cyc(20);

        // mismatching addresses: NACK and silence
        qtag = "R4";
        m_start();
        m_wbyte({7'h5B, 1'b0}, ack);
        chk(!ack, "R4", "NACK on low-bit mismatch", ack, 0);
        m_wbyte(8'h12, ack);
        chk(!ack, "R4", "data ignored after mismatch", ack, 0);
        m_stop();
        m_start();
        m_wbyte({7'h1A, 1'b1}, ack);
        chk(!ack, "R4", "NACK on high-bit mismatch", ack, 0);
        m_rbyte(d, 1'b0);
        chk(d == 8'hFF, "R4", "no data driven after mismatch", d, 8'hFF);
        m_stop();
        qtag = "R1";
        wait_cyc(20);

        // read, fast local side: prefetch avoids stretch
        quiet = 1'b0; rd_lat = 2; req_rises = 0;
        rd_q.push_back(8'hC3); rd_q.push_back(8'h00); rd_q.push_back(8'h7E);
        m_start();
        m_wbyte({7'h5A, 1'b1}, ack);
        chk(ack, "R2 R3", "read address ACK", ack, 1);
        stretch = 0;
        m_rbyte(d, 1'b1); chk(d == 8'hC3, "R8", "read byte 1", d, 8'hC3);
        m_rbyte(d, 1'b1); chk(d == 8'h00, "R8", "read byte 2", d, 8'h00);
        m_rbyte(d, 1'b0); chk(d == 8'h7E, "R8", "read byte 3", d, 8'h7E);
        chk(stretch == 0, "R9", "no stretch with prefetched bytes", stretch, 0);
        quiet = 1'b1; qtag = "R10";
        m_rbyte(d, 1'b0);
        chk(d == 8'hFF, "R10", "SDA released after master NACK", d, 8'hFF);
        chk(req_rises == 3, "R7", "one request per acknowledged slot", req_rises, 3);
        chk(rd_q.size() == 0, "R7", "all read bytes fetched", rd_q.size(), 0);
        m_stop();
        qtag = "R1";
        wait_cyc(20);

        // read, slow local side: SCL stretched before each byte
        quiet = 1'b0; rd_lat = 80;
        rd_q.push_back(8'h81); rd_q.push_back(8'h5A);
        m_start();
        m_wbyte({7'h5A, 1'b1}, ack);
        stretch = 0;
        m_rbyte(d, 1'b1); chk(d == 8'h81, "R8", "slow read byte 1", d, 8'h81);
        m_rbyte(d, 1'b0); chk(d == 8'h5A, "R8", "slow read byte 2", d, 8'h5A);
        chk(stretch >= 80, "R9", "stretch while waiting for read byte", stretch, 80);
        m_stop();
        quiet = 1'b1; qtag = "R1";
        rd_lat = 2;
        wait_cyc(20);

        // repeated START: write then read without STOP
        quiet = 1'b0;
        exp_wr.push_back(8'h66);
        rd_q.push_back(8'h99);
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        m_wbyte(8'h66, ack);
        chk(ack, "R11", "write before restart", ack, 1);
        m_rstart();
        m_wbyte({7'h5A, 1'b1}, ack);
        chk(ack, "R11", "address ACK after restart", ack, 1);
        m_rbyte(d, 1'b0);
        chk(d == 8'h99, "R11", "read after restart", d, 8'h99);
        m_stop();
        quiet = 1'b1; qtag = "R1";
        chk(exp_wr.size() == 0, "R11", "write before restart delivered", exp_wr.size(), 0);
        wait_cyc(20);

        // repeated START to a foreign address
        quiet = 1'b0;
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        m_rstart();
        m_wbyte({7'h5B, 1'b1}, ack);
        chk(!ack, "R11", "NACK for foreign address after restart", ack, 0);
        m_stop();
        quiet = 1'b1; qtag = "R1";
        wait_cyc(20);

        // STOP in the middle of a write byte
        quiet = 1'b0;
        m_start();
        m_wbyte({7'h5A, 1'b0}, ack);
        begin
            bit s;
            m_bit(1'b1, s); m_bit(1'b0, s); m_bit(1'b1, s);
        end
        m_stop();
        quiet = 1'b1; qtag = "R1";
        wait_cyc(40);
        chk(wr_valid == 1'b0, "R1", "partial byte dropped at STOP", wr_valid, 0);

        finish_run();
    end
endmodule